// File: doc/BRIEF.md
# Configurable Clock Crosspoint Switch

This block routes clock signals between sixteen bidirectional ports. Each port can be set to one of two roles. As an output it drives a copy of another port, chosen by a 4-bit index, and that copy can be inverted. As an input its pad value can feed any output. Each port also has a termination-enable bit, which leaves the block as a plain control signal for the pad cell. Signals are single-bit logic. The pad cell combines `pad_out`, `pad_oe` and `pad_in` into the physical bidirectional pin. The route from input to output is purely combinational, so a clock edge on an input reaches the selected outputs with no register delay.

Every setting lives in a register bank. A serial target front end reaches the bank through a simple request bus that carries a 7-bit device identifier, a register address and write data. A small access sequencer serves the bus and has three states:

- `S_IDLE`: waits for a request whose identifier matches.
- `S_WRITE`: commits one register.
- `S_READ`: returns one register.

The transitions are:

- idle-to-write on a matching write request.
- idle-to-read on a matching read request.
- write-to-idle and read-to-idle unconditionally after one cycle.
- idle-to-idle otherwise.

An active-low reset places every port in high impedance, with outputs and termination disabled.

Top module: `xpt_clock_switch`

## Requirements
- R1: While `rst_n` is low, and after it rises with no write, every bit of `pad_oe`, `pad_out` and `term_en` is 0, and both error registers read 0.
- R2: The register for port p is at address p (0x00 to 0x0F). Its fields are: bit 7 enables the output, bit 6 enables termination, bit 5 inverts, and bits 3:0 select the source port. A read returns the written value with bit 4 forced to 0.
- R3: A port with bit 7 set and a valid source drives `pad_out` equal to `pad_in` of the source port, combinationally, and holds `pad_oe` high.
- R4: With bit 5 set, a port with a valid source drives the complement of the source pad.
- R5: A source is invalid when it is the port itself or when the selected port has bit 7 set. An enabled port with an invalid source drives 0 and raises its error flag. Flags for ports 0 to 7 read at address 0x10, and for ports 8 to 15 at 0x11, with bit (p mod 8) belonging to port p.
- R6: A port with bit 7 clear holds `pad_oe` and `pad_out` at 0, and its `pad_in` is usable as a source by other ports.
- R7: `term_en[p]` equals bit 6 of the register for port p, whatever the port's direction.
- R8: A request is served only when `dev_id[6:2]` is 5'b10110 and `dev_id[1:0]` equals `sel`. Any other request is ignored.
- R9: A write sampled at clock edge k changes all fields of the port together at edge k+1. A read sampled at edge k presents `rdata` with `rvalid` high for the one cycle after edge k+1.
- R10: Writes to addresses 0x10 and above change no state. Reads of addresses 0x12 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sel | input | 2 | Strap pins giving the low two identifier bits |
| req | input | 1 | Access request strobe, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| dev_id | input | 7 | Target identifier carried by the request |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | Read data valid, one cycle |
| pad_in | input | 16 | Pad values seen at each port |
| pad_out | output | 16 | Value driven by each port |
| pad_oe | output | 16 | Output enable per port |
| term_en | output | 16 | Termination enable per port |

## Verification
Two functions meet in the same cycle: a register commit that changes the port roles, and the combinational routing that depends on those roles.

The first case makes a source port into an output while another port is still routed from it. The bench checks the consumer's error flag and its forced-zero output on the cycle after the commit edge, and checks that nothing has changed on the cycle before it.

The second case holds a source pad high and then rewrites both the inversion and the enable of the consumer in a single write. The bench judges the output only after the single commit edge, and expects it to be the fully updated value.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int REG_W    = 8;
    localparam int SRC_W    = 4;
    localparam int MAX_PORT = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_READ
    } acc_state_t;

    typedef struct packed {
        logic             oe;
        logic             term;
        logic             inv;
        logic [SRC_W-1:0] src;
    } port_cfg_t;

    function automatic port_cfg_t byte_to_cfg(input logic [REG_W-1:0] b);
        port_cfg_t c;
        c.oe   = b[7];
        c.term = b[6];
        c.inv  = b[5];
        c.src  = b[3:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_byte(input port_cfg_t c);
        return {c.oe, c.term, c.inv, 1'b0, c.src};
    endfunction

endpackage

// File: rtl/xpt_access_fsm.sv
module xpt_access_fsm
    import xpt_pkg::*;
#(
    parameter logic [4:0] ID_BASE = 5'b10110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             req,
    input  logic             we,
    input  logic [6:0]       dev_id,
    input  logic [7:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] bank_rd_data,
    output logic             bank_wr_en,
    output logic [7:0]       bank_addr,
    output logic [REG_W-1:0] bank_wr_data,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);

    acc_state_t state, state_nx;
    logic       id_hit;
    logic [7:0]       addr_q;
    logic [REG_W-1:0] data_q;

    assign id_hit = (dev_id[6:2] == ID_BASE) && (dev_id[1:0] == sel);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req && id_hit) state_nx = we ? S_WRITE : S_READ;
            end
            S_WRITE: state_nx = S_IDLE;
            S_READ:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state == S_IDLE && req && id_hit) begin
            addr_q <= addr;
            data_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (state == S_READ);
            rdata  <= (state == S_READ) ? bank_rd_data : '0;
        end
    end

    assign bank_wr_en   = (state == S_WRITE);
    assign bank_addr    = addr_q;
    assign bank_wr_data = data_q;

    // R9
    write_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |=> (state == S_IDLE));

    // R9
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(state == S_READ));

    // R8
    id_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req && !id_hit) |=> (state == S_IDLE));

endmodule

// File: rtl/xpt_reg_bank.sv
module xpt_reg_bank
    import xpt_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [NPORTS-1:0]      err,
    output port_cfg_t [NPORTS-1:0] cfg,
    output logic [REG_W-1:0]       rd_data
);

    localparam logic [7:0] ERR_LO = 8'h10;
    localparam logic [7:0] ERR_HI = 8'h11;

    logic [2*REG_W-1:0] err_ext;
    assign err_ext = (2*REG_W)'(err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && addr < 8'(NPORTS)) begin
            cfg[addr[SRC_W-1:0]] <= byte_to_cfg(wr_data);
        end
    end

    always_comb begin
        if (addr < 8'(NPORTS))  rd_data = cfg_to_byte(cfg[addr[SRC_W-1:0]]);
        else if (addr == ERR_LO) rd_data = err_ext[REG_W-1:0];
        else if (addr == ERR_HI) rd_data = err_ext[2*REG_W-1:REG_W];
        else                     rd_data = '0;
    end

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

    // R10
    high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= 8'(NPORTS)) |=> $stable(cfg));

endmodule

// File: rtl/xpt_port_mux.sv
module xpt_port_mux
    import xpt_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  port_cfg_t [NPORTS-1:0] cfg,
    input  logic [NPORTS-1:0]      pad_in,
    output logic [NPORTS-1:0]      pad_out,
    output logic [NPORTS-1:0]      pad_oe,
    output logic [NPORTS-1:0]      term_en,
    output logic [NPORTS-1:0]      err
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [SRC_W-1:0] s;
        logic             src_ok;
        logic             routed;

        assign s      = cfg[p].src;
        assign src_ok = (int'(s) < NPORTS) && !cfg[s].oe && (s != SRC_W'(p));
        assign routed = pad_in[s] ^ cfg[p].inv;

        assign pad_oe[p]  = cfg[p].oe;
        assign term_en[p] = cfg[p].term;
        assign pad_out[p] = cfg[p].oe && src_ok && routed;
        assign err[p]     = cfg[p].oe && !src_ok;

        // R6
        oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[p] |-> (!pad_out[p] && !err[p]));

        // R5
        err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err[p] |-> !pad_out[p]);

        // R3
        live_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[p] && !err[p]) |-> !pad_oe[s]);
    end

endmodule

// File: rtl/xpt_clock_switch.sv
module xpt_clock_switch
    import xpt_pkg::*;
#(
    parameter int         NPORTS  = 16,
    parameter logic [4:0] ID_BASE = 5'b10110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              req,
    input  logic              we,
    input  logic [6:0]        dev_id,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rvalid,
    input  logic [NPORTS-1:0] pad_in,
    output logic [NPORTS-1:0] pad_out,
    output logic [NPORTS-1:0] pad_oe,
    output logic [NPORTS-1:0] term_en
);

    port_cfg_t [NPORTS-1:0] cfg;
    logic [NPORTS-1:0]      err;
    logic                   wr_en;
    logic [7:0]             b_addr;
    logic [REG_W-1:0]       b_wdata;
    logic [REG_W-1:0]       b_rdata;

    xpt_access_fsm #(.ID_BASE(ID_BASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .req(req), .we(we),
        .dev_id(dev_id), .addr(addr), .wdata(wdata),
        .bank_rd_data(b_rdata), .bank_wr_en(wr_en), .bank_addr(b_addr),
        .bank_wr_data(b_wdata), .rdata(rdata), .rvalid(rvalid)
    );

    xpt_reg_bank #(.NPORTS(NPORTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(b_addr),
        .wr_data(b_wdata), .err(err), .cfg(cfg), .rd_data(b_rdata)
    );

    xpt_port_mux #(.NPORTS(NPORTS)) u_mux (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .term_en(term_en), .err(err)
    );

endmodule

// File: tb/tb_xpt_clock_switch.sv
module tb_xpt_clock_switch;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] SEL_V = 2'b10;
    localparam logic [6:0] ID_OK = {5'b10110, 2'b10};

    // {port[29:26], cfg[25:18], pad_in[17:2], exp_out[1], exp_err[0]}
    localparam int NV = 8;
    localparam logic [29:0] VEC [NV] = '{
        {4'd0,  8'h83, 16'h0008, 1'b1, 1'b0},   // R3
        {4'd0,  8'h83, 16'h0000, 1'b0, 1'b0},   // R3
        {4'd5,  8'hAC, 16'h1000, 1'b0, 1'b0},   // R4
        {4'd5,  8'hAC, 16'h0000, 1'b1, 1'b0},   // R4
        {4'd7,  8'h87, 16'hFFFF, 1'b0, 1'b1},   // R5 self
        {4'd7,  8'hA7, 16'h0000, 1'b0, 1'b1},   // R5 self inverted
        {4'd15, 8'h80, 16'h0001, 1'b1, 1'b0},   // R3
        {4'd9,  8'h0F, 16'hFFFF, 1'b0, 1'b0}    // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  dev_id = '0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [15:0] term_en;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rd_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpt_clock_switch dut (
        .clk(clk), .rst_n(rst_n), .sel(SEL_V), .req(req), .we(we),
        .dev_id(dev_id), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .term_en(term_en)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [6:0] id);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; dev_id = id;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; dev_id = ID_OK;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk("R9 rvalid", 32'(rvalid), 32'd1);
        d = rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 2);
        chk("R1 oe in reset", 32'(pad_oe), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        pad_in = 16'hFFFF; #1;
        chk("R1 oe", 32'(pad_oe), 32'd0);
        chk("R1 out", 32'(pad_out), 32'd0);
        chk("R1 term", 32'(term_en), 32'd0);
        rd(8'h10, rd_v); chk("R1 err lo", 32'(rd_v), 32'd0);
        rd(8'h11, rd_v); chk("R1 err hi", 32'(rd_v), 32'd0);

        // vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [3:0] p;
            logic [7:0] c;
            p = VEC[i][29:26];
            c = VEC[i][25:18];
            wr({4'h0, p}, c, ID_OK);
            pad_in = VEC[i][17:2]; #1;
            chk($sformatf("R3/R4/R5/R6 vec%0d out", i), 32'(pad_out[p]), 32'(VEC[i][1]));
            chk($sformatf("R6 vec%0d oe", i), 32'(pad_oe[p]), 32'(c[7]));
            rd(p < 8 ? 8'h10 : 8'h11, rd_v);
            chk($sformatf("R5 vec%0d err", i), 32'(rd_v[p[2:0]]), 32'(VEC[i][0]));
            wr({4'h0, p}, 8'h00, ID_OK);
        end

        // R2 readback and field layout
        wr(8'h03, 8'hE5, ID_OK);
        rd(8'h03, rd_v); chk("R2 readback", 32'(rd_v), 32'hE5);
        wr(8'h04, 8'hFF, ID_OK);
        rd(8'h04, rd_v); chk("R2 bit4 zero", 32'(rd_v), 32'hEF);
        wr(8'h03, 8'h00, ID_OK);
        wr(8'h04, 8'h00, ID_OK);

        // R7 termination independent of direction
        wr(8'h06, 8'h40, ID_OK);
        chk("R7 term on input", 32'(term_en[6]), 32'd1);
        chk("R7 oe stays off", 32'(pad_oe[6]), 32'd0);

        // R5 and R9: a source turned into an output invalidates its consumer
        pad_in = 16'h0001;
        wr(8'h0A, 8'h80, ID_OK);                 // port 10 from port 0
        #1 chk("R3 route p10", 32'(pad_out[10]), 32'd1);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 8'h00; wdata = 8'h82; dev_id = ID_OK;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk("R9 not yet applied", 32'(pad_oe[0]), 32'd0);
        chk("R9 route held", 32'(pad_out[10]), 32'd1);
        @(negedge clk);
        chk("R9 applied", 32'(pad_oe[0]), 32'd1);
        chk("R5 consumer zeroed", 32'(pad_out[10]), 32'd0);
        rd(8'h11, rd_v); chk("R5 err hi p10", 32'(rd_v), 32'h04);
        rd(8'h10, rd_v); chk("R5 err lo", 32'(rd_v), 32'h00);
        wr(8'h00, 8'h00, ID_OK);
        wr(8'h0A, 8'h00, ID_OK);

        // R9 all fields in one commit: enable and invert together
        pad_in = 16'h0004;
        wr(8'h01, 8'hA2, ID_OK);
        #1 chk("R9 atomic inv+oe", 32'(pad_out[1]), 32'd0);
        pad_in = 16'h0000; #1;
        chk("R4 inverted low src", 32'(pad_out[1]), 32'd1);
        wr(8'h01, 8'h00, ID_OK);

        // R8 identifier mismatch ignored
        wr(8'h02, 8'h81, {5'b10110, 2'b01});
        chk("R8 sel mismatch", 32'(pad_oe[2]), 32'd0);
        wr(8'h02, 8'h81, {5'b00110, 2'b10});
        chk("R8 base mismatch", 32'(pad_oe[2]), 32'd0);
        rd(8'h02, rd_v); chk("R8 reg untouched", 32'(rd_v), 32'h00);

        // R10 writes above the port range
        wr(8'h10, 8'hFF, ID_OK);
        wr(8'h12, 8'hFF, ID_OK);
        chk("R10 no oe", 32'(pad_oe), 32'd0);
        rd(8'h10, rd_v); chk("R10 err reg", 32'(rd_v), 32'h00);
        rd(8'h12, rd_v); chk("R10 unmapped", 32'(rd_v), 32'h00);

        // R1 mid-run reset
        wr(8'h05, 8'hC0, ID_OK);
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R1 async oe", 32'(pad_oe), 32'd0);
        chk("R1 async term", 32'(term_en), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule